// File: doc/BRIEF.md
# Flash Access Sequencer with Prefetch Gating

This block sits between a system bus shared by several masters and a flash array. It takes one access at a time and marks its start on the array side with a one-cycle strobe. It then counts a programmed number of wait states and signals completion with a one-cycle ready. Reads and writes each have their own wait count. Consecutive accesses can be overlapped: the next access may start in the ready cycle of the one before it, provided a programmed hold gap has passed since the previous start. Overlap can also be turned off, so that every access starts only after the previous one has fully completed.

On every read the block also decides whether that read may launch a speculative fetch of the following line. Three things must all allow it. The requesting master must have its enable bit set. The enable field for the access kind (instruction or data) must allow it. If that field is in burst-only mode, the access must also be a burst. The trigger is raised in the read's ready cycle, and the address of the next line is presented with it.

Configuration is loaded through a write port. A configuration write is applied only while no access is in flight.

The control state machine has three states:
- **ST_IDLE**: no access in flight. It goes to ST_WAIT when a request is accepted and the access has a nonzero wait count. It goes straight to ST_RESP when the wait count is zero.
- **ST_WAIT**: the wait count runs down. When the count reaches one, the next state is ST_RESP.
- **ST_RESP**: the ready cycle. If overlap is enabled and a new request is accepted in this cycle, the machine goes to ST_WAIT or ST_RESP, chosen the same way as from ST_IDLE. Otherwise it returns to ST_IDLE.

Top module: `flash_seq_ctrl`

## Requirements
- R1: A read accepted in cycle a, with read wait field N (3 bits, 0..7 wait states), raises `rdy` in cycle a+N+1 only. `rdy` is never high two cycles in a row unless a new access was accepted in the first of those cycles.
- R2: A write uses the 2-bit write wait field instead. Values 1, 2 and 3 give that many wait states, and value 0 is treated as 3. `rdy` comes in cycle a+W+1.
- R3: When the 3-bit gap field G is in the range 1..6, overlap is on. A request presented in cycle p after an access accepted in cycle a, whose ready came or will come in cycle r, is accepted in cycle max(p, a+G+1, r). It may therefore start in the previous access's ready cycle.
- R4: Gap field values 7 and 0 turn overlap off. In that case the request is accepted in cycle max(p, r+1), and a strobe never coincides with `rdy`.
- R5: Masters 0 to 4 each have one enable bit, with bit i belonging to master i. A read from a master whose bit is clear, or from any master ID of 5 or above, never raises `pf_trig`.
- R6: Each prefetch mode field (data and instruction) is 2 bits. 00 means no read triggers. 01 means only burst reads trigger. 11 means any read triggers. 10 is treated as 00. The instruction field governs reads with `req_instr`=1, and the data field governs the others.
- R7: `pf_trig` is high only in the ready cycle of a read that meets R5 and R6, and only for that cycle. Writes never raise it. With it, `pf_addr` holds the accessed address rounded down to a 32-byte line plus one line.
- R8: After reset, `rdy`, `pf_trig` and `ary_strobe` are low. All prefetch enables are cleared. The read wait is 7, the write wait is 3, and overlap is off.
- R9: `cfg_we` is acted on only in ST_IDLE. Writes at any other time leave the configuration unchanged. A loaded value takes effect from the next cycle.
- R10: `ary_strobe` is high only in an acceptance cycle, with `ary_addr`/`ary_write` equal to the request fields. A new strobe never occurs while an earlier access is in flight, except in that access's ready cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration load strobe |
| cfg_rd_wait | input | 3 | Read wait states |
| cfg_wr_wait | input | 2 | Write wait states (0 treated as 3) |
| cfg_pipe_gap | input | 3 | Hold gap 1..6; 0 or 7 turn overlap off |
| cfg_data_pf | input | 2 | Data prefetch mode |
| cfg_inst_pf | input | 2 | Instruction prefetch mode |
| cfg_master_pf | input | NUM_MST | Per-master prefetch enable |
| req_valid | input | 1 | Request present, held until strobe |
| req_addr | input | ADDR_W | Request byte address |
| req_master | input | MST_W | Requesting master ID |
| req_write | input | 1 | 1 = write, 0 = read |
| req_instr | input | 1 | 1 = instruction fetch |
| req_burst | input | 1 | 1 = burst access |
| ary_strobe | output | 1 | Access accepted and started this cycle |
| ary_addr | output | ADDR_W | Array address |
| ary_write | output | 1 | Array direction |
| rdy | output | 1 | Access complete (one cycle) |
| pf_trig | output | 1 | Prefetch of the next line requested |
| pf_addr | output | ADDR_W | Next-line address for the prefetch |

## Verification
Three events can fall in the same cycle: the ready of one access, its prefetch trigger, and the strobe of the next access. This happens when overlap is on and the gap has already expired by the ready cycle. The bench provokes it by issuing prefetch-eligible reads back to back, with a read wait of 2 and a gap of 2. It then checks three things for that cycle: the new strobe lands exactly on the previous ready cycle; the trigger and line address belong to the completing read and not to the new one; and the new access's own ready arrives at its acceptance cycle plus its wait count plus one. With overlap off, the same traffic must show a one-cycle separation.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam int RD_WS_W = 3;
    localparam int WR_WS_W = 2;
    localparam int GAP_W   = 3;
    localparam int CNT_W   = RD_WS_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_RESP
    } acc_state_e;

    typedef enum logic [1:0] {
        PF_NONE  = 2'b00,
        PF_BURST = 2'b01,
        PF_RSVD  = 2'b10,
        PF_ANY   = 2'b11
    } pf_mode_e;

    typedef struct packed {
        logic [RD_WS_W-1:0] rd_ws;
        logic [WR_WS_W-1:0] wr_ws;
        logic [GAP_W-1:0]   hold;
        logic               pipe_off;
        pf_mode_e           dpf;
        pf_mode_e           ipf;
    } timing_t;

endpackage

// File: rtl/fsc_cfg_regs.sv
module fsc_cfg_regs
    import flash_seq_pkg::*;
#(
    parameter int NUM_MST = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_ok,
    input  logic                cfg_we,
    input  logic [RD_WS_W-1:0]  cfg_rd_wait,
    input  logic [WR_WS_W-1:0]  cfg_wr_wait,
    input  logic [GAP_W-1:0]    cfg_pipe_gap,
    input  logic [1:0]          cfg_data_pf,
    input  logic [1:0]          cfg_inst_pf,
    input  logic [NUM_MST-1:0]  cfg_master_pf,
    output timing_t             tim,
    output logic [NUM_MST-1:0]  mpf
);

    localparam logic [GAP_W-1:0] GAP_OFF = '1;

    logic [RD_WS_W-1:0] rd_q;
    logic [WR_WS_W-1:0] wr_q;
    logic [GAP_W-1:0]   gap_q;
    logic [1:0]         dpf_q;
    logic [1:0]         ipf_q;
    logic [NUM_MST-1:0] mpf_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q  <= '1;
            wr_q  <= '1;
            gap_q <= GAP_OFF;
            dpf_q <= '0;
            ipf_q <= '0;
            mpf_q <= '0;
        end else if (cfg_we && load_ok) begin
            rd_q  <= cfg_rd_wait;
            wr_q  <= cfg_wr_wait;
            gap_q <= cfg_pipe_gap;
            dpf_q <= cfg_data_pf;
            ipf_q <= cfg_inst_pf;
            mpf_q <= cfg_master_pf;
        end
    end

    function automatic pf_mode_e safe_mode(input logic [1:0] raw);
        pf_mode_e m;
        m = pf_mode_e'(raw);
        return (m == PF_RSVD) ? PF_NONE : m;
    endfunction

    always_comb begin
        tim.rd_ws    = rd_q;
        tim.wr_ws    = (wr_q == '0) ? '1 : wr_q;
        tim.hold     = gap_q;
        tim.pipe_off = (gap_q == '0) || (gap_q == GAP_OFF);
        tim.dpf      = safe_mode(dpf_q);
        tim.ipf      = safe_mode(ipf_q);
        mpf          = mpf_q;
    end

endmodule

// File: rtl/fsc_gap_timer.sv
module fsc_gap_timer #(
    parameter int GAP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [GAP_W-1:0] hold,
    output logic             gap_ok
);

    logic [GAP_W-1:0] since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            since_q <= '1;
        else if (start)
            since_q <= '0;
        else if (since_q != '1)
            since_q <= since_q + 1'b1;
    end

    assign gap_ok = (since_q >= hold);

endmodule

// File: rtl/fsc_pf_gate.sv
module fsc_pf_gate
    import flash_seq_pkg::*;
#(
    parameter int NUM_MST = 5,
    parameter int MST_W   = 3
) (
    input  logic [MST_W-1:0]   master,
    input  logic               is_write,
    input  logic               is_instr,
    input  logic               is_burst,
    input  logic [NUM_MST-1:0] mpf,
    input  pf_mode_e           dpf,
    input  pf_mode_e           ipf,
    output logic               pf_ok
);

    logic     mst_en;
    logic     kind_ok;
    pf_mode_e mode;

    always_comb begin
        mst_en = 1'b0;
        for (int i = 0; i < NUM_MST; i++) begin
            if (master == MST_W'(i))
                mst_en = mpf[i];
        end
    end

    always_comb begin
        mode = is_instr ? ipf : dpf;
        unique case (mode)
            PF_ANY:   kind_ok = 1'b1;
            PF_BURST: kind_ok = is_burst;
            default:  kind_ok = 1'b0;
        endcase
    end

    assign pf_ok = mst_en && kind_ok && !is_write;

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int NUM_MST = 5,
    parameter int MST_W   = 3,
    parameter int LINE_LG = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [2:0]         cfg_rd_wait,
    input  logic [1:0]         cfg_wr_wait,
    input  logic [2:0]         cfg_pipe_gap,
    input  logic [1:0]         cfg_data_pf,
    input  logic [1:0]         cfg_inst_pf,
    input  logic [NUM_MST-1:0] cfg_master_pf,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [MST_W-1:0]   req_master,
    input  logic               req_write,
    input  logic               req_instr,
    input  logic               req_burst,
    output logic               ary_strobe,
    output logic [ADDR_W-1:0]  ary_addr,
    output logic               ary_write,
    output logic               rdy,
    output logic               pf_trig,
    output logic [ADDR_W-1:0]  pf_addr
);

    localparam int LINE_W = ADDR_W - LINE_LG;

    timing_t            tim;
    logic [NUM_MST-1:0] mpf;
    logic               gap_ok;
    logic               pf_ok;
    logic               can_take;
    logic               accept;
    logic [CNT_W-1:0]   ws_sel;

    acc_state_e         state_q, state_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [ADDR_W-1:0]  addr_q;
    logic               wr_q;
    logic               pf_q;
    logic [LINE_W-1:0]  next_line;

    fsc_cfg_regs #(.NUM_MST(NUM_MST)) cfg_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .load_ok       (state_q == ST_IDLE),
        .cfg_we        (cfg_we),
        .cfg_rd_wait   (cfg_rd_wait),
        .cfg_wr_wait   (cfg_wr_wait),
        .cfg_pipe_gap  (cfg_pipe_gap),
        .cfg_data_pf   (cfg_data_pf),
        .cfg_inst_pf   (cfg_inst_pf),
        .cfg_master_pf (cfg_master_pf),
        .tim           (tim),
        .mpf           (mpf)
    );

    fsc_gap_timer #(.GAP_W(GAP_W)) gap_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (accept),
        .hold   (tim.hold),
        .gap_ok (gap_ok)
    );

    fsc_pf_gate #(.NUM_MST(NUM_MST), .MST_W(MST_W)) pfg_i (
        .master   (req_master),
        .is_write (req_write),
        .is_instr (req_instr),
        .is_burst (req_burst),
        .mpf      (mpf),
        .dpf      (tim.dpf),
        .ipf      (tim.ipf),
        .pf_ok    (pf_ok)
    );

    // acceptance and next-state logic
    always_comb begin
        unique case (state_q)
            ST_IDLE: can_take = tim.pipe_off || gap_ok;
            ST_RESP: can_take = !tim.pipe_off && gap_ok;
            default: can_take = 1'b0;
        endcase
        accept = req_valid && can_take;
        ws_sel = req_write ? CNT_W'(tim.wr_ws) : tim.rd_ws;

        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE, ST_RESP: begin
                if (accept) begin
                    cnt_d   = ws_sel;
                    state_d = (ws_sel == '0) ? ST_RESP : ST_WAIT;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_WAIT: begin
                cnt_d = cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1))
                    state_d = ST_RESP;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            addr_q  <= '0;
            wr_q    <= 1'b0;
            pf_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (accept) begin
                addr_q <= req_addr;
                wr_q   <= req_write;
                pf_q   <= pf_ok;
            end
        end
    end

    // outputs
    always_comb begin
        next_line  = addr_q[ADDR_W-1:LINE_LG] + 1'b1;
        ary_strobe = accept;
        ary_addr   = accept ? req_addr : addr_q;
        ary_write  = accept ? req_write : wr_q;
        rdy        = (state_q == ST_RESP);
        pf_trig    = rdy && pf_q;
        pf_addr    = {next_line, {LINE_LG{1'b0}}};
    end

endmodule

// File: rtl/flash_seq_ctrl_chk.sv
module flash_seq_ctrl_chk
    import flash_seq_pkg::*;
#(
    parameter int NUM_MST = 5,
    parameter int MST_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_write,
    input logic [MST_W-1:0]   req_master,
    input logic               ary_strobe,
    input logic               rdy,
    input logic               pf_trig,
    input logic               cfg_we,
    input acc_state_e         state_q,
    input timing_t            tim,
    input logic [NUM_MST-1:0] mpf
);

    logic             wr_c;
    logic [MST_W-1:0] mst_c;
    logic [GAP_W-1:0] since_c;
    logic             inflight_c;
    logic             mst_en_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_c       <= 1'b0;
            mst_c      <= '0;
            since_c    <= '1;
            inflight_c <= 1'b0;
        end else begin
            if (ary_strobe) begin
                wr_c  <= req_write;
                mst_c <= req_master;
            end
            if (ary_strobe)
                since_c <= '0;
            else if (since_c != '1)
                since_c <= since_c + 1'b1;
            if (ary_strobe)
                inflight_c <= 1'b1;
            else if (rdy)
                inflight_c <= 1'b0;
        end
    end

    always_comb begin
        mst_en_c = 1'b0;
        for (int i = 0; i < NUM_MST; i++)
            if (mst_c == MST_W'(i)) mst_en_c = mpf[i];
    end

    // R1
    rdy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && !ary_strobe) |=> !rdy);

    // R7
    pf_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf_trig |-> !wr_c);

    // R5
    master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf_trig |-> mst_en_c);

    // R3
    gap_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ary_strobe && !tim.pipe_off) |-> (since_c >= tim.hold));

    // R4
    nopipe_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ary_strobe && tim.pipe_off) |-> !rdy);

    // R10
    single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ary_strobe |-> (!inflight_c || rdy));

    // R9
    cfg_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && state_q != ST_IDLE) |=> ($stable(tim) && $stable(mpf)));

endmodule

bind flash_seq_ctrl flash_seq_ctrl_chk #(.NUM_MST(NUM_MST), .MST_W(MST_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_write  (req_write),
    .req_master (req_master),
    .ary_strobe (ary_strobe),
    .rdy        (rdy),
    .pf_trig    (pf_trig),
    .cfg_we     (cfg_we),
    .state_q    (state_q),
    .tim        (tim),
    .mpf        (mpf)
);

// File: tb/flash_seq_ctrl_tb_top.sv
module flash_seq_ctrl_tb_top;

    localparam int AW = 16;
    localparam int NM = 5;
    localparam int MW = 3;
    localparam int LB = 5;

    typedef struct {
        int            rcyc;
        bit            pf;
        logic [AW-1:0] pfa;
        string         ltag;
        string         ptag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_rd_wait = '0;
    logic [1:0]    cfg_wr_wait = '0;
    logic [2:0]    cfg_pipe_gap = '0;
    logic [1:0]    cfg_data_pf = '0;
    logic [1:0]    cfg_inst_pf = '0;
    logic [NM-1:0] cfg_master_pf = '0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [MW-1:0] req_master = '0;
    logic          req_write = 1'b0;
    logic          req_instr = 1'b0;
    logic          req_burst = 1'b0;
    logic          ary_strobe, ary_write, rdy, pf_trig;
    logic [AW-1:0] ary_addr, pf_addr;

    always #2 clk = ~clk;

    flash_seq_ctrl #(.ADDR_W(AW), .NUM_MST(NM), .MST_W(MW), .LINE_LG(LB)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_rd_wait(cfg_rd_wait),
        .cfg_wr_wait(cfg_wr_wait), .cfg_pipe_gap(cfg_pipe_gap), .cfg_data_pf(cfg_data_pf),
        .cfg_inst_pf(cfg_inst_pf), .cfg_master_pf(cfg_master_pf), .req_valid(req_valid),
        .req_addr(req_addr), .req_master(req_master), .req_write(req_write),
        .req_instr(req_instr), .req_burst(req_burst), .ary_strobe(ary_strobe),
        .ary_addr(ary_addr), .ary_write(ary_write), .rdy(rdy), .pf_trig(pf_trig),
        .pf_addr(pf_addr)
    );

    int    cyc = 0;
    int    n_tot = 0;
    int    n_fail = 0;
    bit    done = 0;
    item_t sb_q[$];
    item_t mon_it;

    // bench-side model of the configuration
    int      m_rd = 7, m_wr = 3, m_hold = 7;
    bit      m_off = 1;
    int      m_dpf = 0, m_ipf = 0;
    bit [4:0] m_mpf = '0;
    int      prev_a = -1000, prev_r = -1000;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_tot++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    endtask

    task automatic cfg_set(input int rd, input int wr, input int pg,
                           input int dp, input int ip, input bit [4:0] mp);
        while (sb_q.size() != 0) @(negedge clk);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_rd_wait = 3'(rd); cfg_wr_wait = 2'(wr); cfg_pipe_gap = 3'(pg);
        cfg_data_pf = 2'(dp); cfg_inst_pf = 2'(ip); cfg_master_pf = mp;
        @(negedge clk);
        cfg_we = 1'b0;
        m_rd = rd;
        m_wr = (wr == 0) ? 3 : wr;
        m_hold = pg;
        m_off = (pg == 0 || pg == 7);
        m_dpf = (dp == 2) ? 0 : dp;
        m_ipf = (ip == 2) ? 0 : ip;
        m_mpf = mp;
    endtask

    // driver: presents one request, checks its acceptance cycle, pushes the expectation
    task automatic acc(input int m, input bit w, input bit ins, input bit bu,
                       input logic [AW-1:0] ad, input bit poke);
        int p, a, ea, ws, mode;
        bit men;
        item_t it;
        logic [AW-LB-1:0] ln;
        req_valid = 1'b1; req_master = MW'(m); req_write = w;
        req_instr = ins; req_burst = bu; req_addr = ad;
        p = cyc;
        #1;
        while (!ary_strobe) begin
            @(negedge clk);
            #1;
        end
        a = cyc;
        if (m_off) begin
            ea = (p > prev_r + 1) ? p : prev_r + 1;
            chk(a == ea, "R4", "accept cycle", a - p, ea - p);
        end else begin
            ea = p;
            if (prev_a + m_hold + 1 > ea) ea = prev_a + m_hold + 1;
            if (prev_r > ea) ea = prev_r;
            chk(a == ea, "R3", "accept cycle", a - p, ea - p);
        end
        chk(ary_addr == ad && ary_write == w, "R10", "strobe fields",
            int'(ary_addr), int'(ad));
        ws = w ? m_wr : m_rd;
        mode = ins ? m_ipf : m_dpf;
        men = (m < NM) && m_mpf[m];
        it.rcyc = a + ws + 1;
        it.pf = !w && men && (mode == 3 || (mode == 1 && bu));
        ln = ad[AW-1:LB] + 1'b1;
        it.pfa = {ln, {LB{1'b0}}};
        it.ltag = w ? "R2" : "R1";
        it.ptag = !men ? "R5" : (w ? "R7" : "R6");
        sb_q.push_back(it);
        prev_a = a;
        prev_r = a + ws + 1;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            // R9: configuration write while the access is still waiting
            cfg_we = 1'b1;
            cfg_rd_wait = 3'd0; cfg_pipe_gap = 3'd1; cfg_data_pf = 2'd3;
            cfg_master_pf = '1;
            @(negedge clk);
            cfg_we = 1'b0;
        end
    endtask

    // monitor: pops expectations as ready cycles appear
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            if (rdy) begin
                if (sb_q.size() == 0) begin
                    chk(0, "R1", "ready with nothing pending", 1, 0);
                end else begin
                    mon_it = sb_q.pop_front();
                    chk(cyc == mon_it.rcyc, mon_it.ltag, "ready cycle", cyc, mon_it.rcyc);
                    chk(pf_trig == mon_it.pf, mon_it.ptag, "prefetch trigger",
                        int'(pf_trig), int'(mon_it.pf));
                    if (mon_it.pf)
                        chk(pf_addr == mon_it.pfa, "R7", "prefetch line address",
                            int'(pf_addr), int'(mon_it.pfa));
                end
            end else if (pf_trig) begin
                chk(0, "R7", "trigger outside ready", 1, 0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tot++;
        n_fail++;
        $display("FAIL watchdog expired, %0d items pending", sb_q.size());
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R8: quiet outputs after reset
        chk(!rdy && !pf_trig && !ary_strobe, "R8", "reset outputs",
            int'({rdy, pf_trig, ary_strobe}), 0);
        @(negedge clk);

        // R8: default timing (read 7, write 3, overlap off, no prefetch)
        acc(0, 0, 0, 1, 16'h0100, 0);
        acc(0, 1, 0, 0, 16'h0104, 0);

        // overlap gap 2, read 2, write 1
        cfg_set(2, 1, 2, 3, 1, 5'b00101);
        acc(0, 0, 0, 0, 16'h1234, 0);   // data any  -> trigger
        acc(0, 0, 1, 0, 16'h2000, 0);   // instr burst-only, single -> none
        acc(0, 0, 1, 1, 16'h2020, 0);   // instr burst -> trigger
        acc(1, 0, 0, 1, 16'h3000, 0);   // master disabled
        acc(2, 0, 0, 1, 16'h3FE4, 0);   // master 2 enabled
        acc(2, 1, 0, 0, 16'h4000, 0);   // write never triggers
        acc(5, 0, 0, 1, 16'h4100, 0);   // id out of range
        acc(2, 0, 0, 0, 16'hFFE0, 0);   // line wrap

        // gap 6, read 0, reserved write and data mode
        cfg_set(0, 0, 6, 2, 3, 5'b11111);
        acc(3, 0, 0, 1, 16'h5000, 0);   // reserved data mode -> none
        acc(3, 0, 1, 0, 16'h5040, 0);   // instr any -> trigger
        acc(4, 1, 0, 0, 16'h5080, 0);   // write wait 3
        acc(4, 0, 1, 1, 16'h50C0, 0);

        // overlap off, burst-only data for master 4
        cfg_set(3, 2, 7, 1, 0, 5'b10000);
        acc(4, 0, 0, 1, 16'h6000, 0);
        acc(4, 0, 0, 0, 16'h6020, 0);
        acc(4, 0, 1, 1, 16'h6040, 0);
        acc(4, 1, 0, 0, 16'h6060, 0);

        // reserved gap value, then a configuration write while busy
        cfg_set(2, 2, 0, 0, 0, 5'b00000);
        acc(0, 0, 0, 1, 16'h7000, 1);
        acc(0, 0, 0, 1, 16'h7020, 0);   // still read 2, overlap off, no trigger
        acc(1, 1, 0, 0, 16'h7040, 0);

        while (sb_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end

endmodule